// File: doc/BRIEF.md
# Locked Staged Watchdog

This block is a watchdog peripheral built from two parts: a down-counting tick timer and a staged watchdog counter. The timer counts pulses of a 1 MHz enable input and emits an expiry pulse each time it wraps. The watchdog counts those timer expiries against a programmed period. Each full period advances an expiry stage. The first stage raises an interrupt. The fourth stage raises a reset request for the system reset controller.

Software controls the block over a simple single-cycle write bus with a combinational read port. It programs the timer, writes the watchdog configuration and starts the counter with a command write. It keeps the system alive by issuing the start command again, which acts as a feed. Stopping the watchdog is guarded: a disable command takes effect only when the unlock key was written to the unlock register just before it.

Top module: `wdg_top`

## Requirements
- R1: Register map by byte address: timer preload 0x00 (bit 31 enable, bit 30 auto-reload, bits [29:0] reload count), watchdog config 0x10 (bits [3:0] timer select, bits [11:4] period, bit 12 interrupt enable, bit 15 reset-request enable), command 0x18, unlock 0x1C. Reading 0x00 returns the preload fields, reading 0x10 returns the config fields with all other bits zero, and every other address reads 0.
- R2: An enabled auto-reload timer produces one expiry every reload+1 cycles in which tick_en is high.
- R3: With bit 30 clear, the timer stops after its first expiry and its enable bit then reads 0. Writing 0 to the preload register stops the timer.
- R4: A running watchdog whose timer select equals 5 advances one watchdog expiry every `period` timer expiries; a period of 0 acts as 1. With any other select value, timer expiries are ignored.
- R5: The expiry stage counts watchdog expiries up to 4 and holds there. irq_o rises at the first watchdog expiry when bit 12 is set. rst_req_o is high while the stage is 4 and bit 15 is set.
- R6: A command write with bit 0 set starts or restarts the watchdog. It reloads the period, clears the stage and clears irq_o.
- R7: A command write with bit 1 set stops the watchdog only when the last unlock-register write held 0xC45A in bits [15:0] and no command write came after it. Any other unlock value clears a pending unlock. A locked disable command is ignored.
- R8: An accepted disable clears irq_o and the stage. Later timer expiries have no effect until the next start.
- R9: After reset irq_o and rst_req_o are low, and both registers read 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 1 MHz tick enable for the timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Reset request, fourth stage |

## Verification
The hardest situation to reach is the fourth stage. It appears only after four full watchdog periods, and each of those periods is itself a multiple of the timer reload. Near misses of the unlock rule (a stale unlock, an overwritten unlock, an unlock consumed by a restart) are just as hard, because each is visible only as a reset request that still arrives. The bench sweeps small periods, reloads and both enable bits tick by tick up to and past the fourth stage. It compares each output against the floor-division count of timer and watchdog expiries. Directed sequences then place each near-miss unlock before a disable and watch rst_req_o still rise on schedule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned PERIOD_W   = 8;
  localparam int unsigned SEL_W      = 4;
  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;

  localparam logic [3:0] OFS_PRELOAD = 4'h0;
  localparam logic [3:0] OFS_CONFIG  = 4'h0;
  localparam logic [3:0] OFS_COMMAND = 4'h8;
  localparam logic [3:0] OFS_UNLOCK  = 4'hC;

  typedef struct packed {
    logic                rst_en;
    logic                irq_en;
    logic [PERIOD_W-1:0] period;
    logic [SEL_W-1:0]    sel;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned CNT_W = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] ptv_o,
  output logic        expire_o
);
  logic             en_q, en_d;
  logic             per_q, per_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cur_q, cur_d;

  assign expire_o = en_q && tick_en && (cur_q == '0);

  always_comb begin
    en_d     = en_q;
    per_d    = per_q;
    reload_d = reload_q;
    cur_d    = cur_q;
    if (wr_en) begin
      en_d     = wdata[31];
      per_d    = wdata[30];
      reload_d = wdata[CNT_W-1:0];
      cur_d    = wdata[CNT_W-1:0];
    end else if (en_q && tick_en) begin
      if (cur_q == '0) begin
        cur_d = reload_q;
        if (!per_q) en_d = 1'b0;
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      reload_q <= '0;
      cur_q    <= '0;
    end else begin
      en_q     <= en_d;
      per_q    <= per_d;
      reload_q <= reload_d;
      cur_q    <= cur_d;
    end
  end

  always_comb begin
    ptv_o            = '0;
    ptv_o[31]        = en_q;
    ptv_o[30]        = per_q;
    ptv_o[CNT_W-1:0] = reload_q;
  end

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !per_q && !wr_en |=> !en_q); // R3
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && per_q && !wr_en |=> cur_q == $past(reload_q)); // R2
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int unsigned TIMER_ID = 5,
  parameter int unsigned STAGES   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire_i,
  input  logic        cfg_wr,
  input  logic        cmd_wr,
  input  logic        unlk_wr,
  input  logic [15:0] wdata,
  output logic [31:0] cfg_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int unsigned SW = $clog2(STAGES + 1);
  localparam logic [SW-1:0] STAGE_TOP = SW'(STAGES);

  wdg_cfg_t            cfg_q, cfg_d;
  logic                run_q, run_d;
  logic                unlk_q, unlk_d;
  logic                irq_q, irq_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [SW-1:0]       stage_q, stage_d;

  logic sel_hit, wd_tick, wd_wrap, disable_ok, start;

  assign sel_hit    = (cfg_q.sel == SEL_W'(TIMER_ID));
  assign wd_tick    = run_q && expire_i && sel_hit;
  assign wd_wrap    = wd_tick && (cnt_q <= PERIOD_W'(1));
  assign disable_ok = cmd_wr && wdata[1] && unlk_q;
  assign start      = cmd_wr && wdata[0] && !disable_ok;

  always_comb begin
    cfg_d   = cfg_q;
    run_d   = run_q;
    unlk_d  = unlk_q;
    irq_d   = irq_q;
    cnt_d   = cnt_q;
    stage_d = stage_q;
    if (cfg_wr) begin
      cfg_d.rst_en = wdata[15];
      cfg_d.irq_en = wdata[12];
      cfg_d.period = wdata[11:4];
      cfg_d.sel    = wdata[3:0];
    end
    if (unlk_wr)     unlk_d = (wdata == UNLOCK_KEY);
    else if (cmd_wr) unlk_d = 1'b0;
    if (disable_ok) begin
      run_d   = 1'b0;
      stage_d = '0;
      irq_d   = 1'b0;
    end else if (start) begin
      run_d   = 1'b1;
      cnt_d   = cfg_q.period;
      stage_d = '0;
      irq_d   = 1'b0;
    end else if (wd_tick) begin
      if (wd_wrap) begin
        cnt_d = cfg_q.period;
        if (stage_q != STAGE_TOP) stage_d = stage_q + 1'b1;
        if (cfg_q.irq_en) irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      run_q   <= 1'b0;
      unlk_q  <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      run_q   <= run_d;
      unlk_q  <= unlk_d;
      irq_q   <= irq_d;
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = cfg_q.rst_en && (stage_q == STAGE_TOP);

  always_comb begin
    cfg_o        = '0;
    cfg_o[15]    = cfg_q.rst_en;
    cfg_o[12]    = cfg_q.irq_en;
    cfg_o[11:4]  = cfg_q.period;
    cfg_o[3:0]   = cfg_q.sel;
  end

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q <= STAGE_TOP); // R5
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stage_q) |-> (stage_q == '0 || stage_q == $past(stage_q) + 1'b1)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[0] && !wdata[1] |=> stage_q == '0 && !irq_q && run_q); // R6
  AST_LOCKED_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[1] && !wdata[0] && !unlk_q && run_q |=> run_q); // R7
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start |=> $stable(stage_q) && !irq_q); // R8
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 30,
  parameter int unsigned TIMER_ID = 5,
  parameter int unsigned STAGES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic       grp_wdg;
  logic [3:0] ofs;
  logic       tmr_wr, cfg_wr, cmd_wr, unlk_wr, expire;
  logic [31:0] ptv_rd, cfg_rd;

  assign grp_wdg = bus_addr[4];
  assign ofs     = bus_addr[3:0];
  assign tmr_wr  = bus_wr && !grp_wdg && (ofs == OFS_PRELOAD);
  assign cfg_wr  = bus_wr &&  grp_wdg && (ofs == OFS_CONFIG);
  assign cmd_wr  = bus_wr &&  grp_wdg && (ofs == OFS_COMMAND);
  assign unlk_wr = bus_wr &&  grp_wdg && (ofs == OFS_UNLOCK);

  wdg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (tmr_wr),
    .wdata    (bus_wdata),
    .ptv_o    (ptv_rd),
    .expire_o (expire)
  );

  wdg_core #(.TIMER_ID(TIMER_ID), .STAGES(STAGES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .cfg_wr    (cfg_wr),
    .cmd_wr    (cmd_wr),
    .unlk_wr   (unlk_wr),
    .wdata     (bus_wdata[15:0]),
    .cfg_o     (cfg_rd),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (!grp_wdg && ofs == OFS_PRELOAD)     bus_rdata = ptv_rd;
    else if (grp_wdg && ofs == OFS_CONFIG)  bus_rdata = cfg_rd;
  end

  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) && u_core.cfg_q.irq_en |-> irq_o); // R5
endmodule

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;
  int          checks = 0;
  int          fails  = 0;

  always #5 clk = ~clk;

  wdg_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  function automatic logic [31:0] cfgw(input int p, input int ie, input int re, input int sel);
    return (32'(re) << 15) | (32'(ie) << 12) | (32'(p) << 4) | 32'(sel);
  endfunction

  task automatic sweep(input int p, input int r, input int ie, input int re);
    int total, w;
    wr(5'h00, 32'hC000_0000 | 32'(r));
    wr(5'h10, cfgw(p, ie, re, 5));
    wr(5'h18, 32'h1);
    total = 4 * p * (r + 1) + 2;
    for (int t = 1; t <= total; t++) begin
      ticks(1);
      w = (t / (r + 1)) / p;
      check("R2/R4/R5 irq", {31'b0, irq_o}, {31'b0, (ie != 0) && (w >= 1)});
      check("R5 rst_req", {31'b0, rst_req_o}, {31'b0, (re != 0) && (w >= 4)});
    end
    wr(5'h1C, 32'h0000_C45A);
    wr(5'h18, 32'h2);
    check("R8 irq cleared by disable", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irq", {31'b0, irq_o}, 32'h0);
    check("R9 rst_req", {31'b0, rst_req_o}, 32'h0);
    rd(5'h00, d); check("R9 preload", d, 32'h0);
    rd(5'h10, d); check("R9 config", d, 32'h0);

    // R1 register map readback
    wr(5'h00, 32'hC000_0123);
    rd(5'h00, d); check("R1 preload readback", d, 32'hC000_0123);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d); check("R1 config readback", d, 32'h0000_9FFF);
    rd(5'h18, d); check("R1 command reads 0", d, 32'h0);
    rd(5'h1C, d); check("R1 unlock reads 0", d, 32'h0);

    // R2 R4 R5 sweep over period, reload and enables
    for (int p = 1; p <= 4; p++)
      for (int r = 0; r <= 2; r++)
        for (int e = 0; e < 4; e++)
          sweep(p, r, e & 1, e >> 1);

    // common setup: reload 1 (2 ticks per timer expiry), period 2 -> 4 ticks per stage
    wr(5'h00, 32'hC000_0001);
    wr(5'h10, cfgw(2, 1, 1, 5));

    // R6 feed
    wr(5'h18, 32'h1);
    ticks(12);
    check("R6 irq before feed", {31'b0, irq_o}, 32'h1);
    check("R6 no rst at stage 3", {31'b0, rst_req_o}, 32'h0);
    wr(5'h18, 32'h1);
    check("R6 restart clears irq", {31'b0, irq_o}, 32'h0);
    ticks(12);
    check("R6 no rst after feed", {31'b0, rst_req_o}, 32'h0);
    ticks(4);
    check("R6 rst after four fresh periods", {31'b0, rst_req_o}, 32'h1);

    // R7 disable without unlock ignored
    wr(5'h00, 32'hC000_0001);
    wr(5'h18, 32'h1);
    wr(5'h18, 32'h2);
    ticks(16);
    check("R7 locked disable ignored", {31'b0, rst_req_o}, 32'h1);

    // R7 wrong key clears pending unlock
    wr(5'h00, 32'hC000_0001);
    wr(5'h18, 32'h1);
    wr(5'h1C, 32'h0000_C45A);
    wr(5'h1C, 32'h0000_1234);
    wr(5'h18, 32'h2);
    ticks(16);
    check("R7 overwritten unlock", {31'b0, rst_req_o}, 32'h1);

    // R7 unlock consumed by another command
    wr(5'h00, 32'hC000_0001);
    wr(5'h18, 32'h1);
    wr(5'h1C, 32'h0000_C45A);
    wr(5'h18, 32'h1);
    wr(5'h18, 32'h2);
    ticks(16);
    check("R7 consumed unlock", {31'b0, rst_req_o}, 32'h1);

    // R8 accepted disable
    wr(5'h00, 32'hC000_0001);
    wr(5'h18, 32'h1);
    ticks(4);
    check("R8 irq before disable", {31'b0, irq_o}, 32'h1);
    wr(5'h1C, 32'h0000_C45A);
    wr(5'h18, 32'h2);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    ticks(20);
    check("R8 stays quiet irq", {31'b0, irq_o}, 32'h0);
    check("R8 stays quiet rst", {31'b0, rst_req_o}, 32'h0);
    wr(5'h18, 32'h1);
    ticks(4);
    check("R8 restart after disable", {31'b0, irq_o}, 32'h1);

    // R4 timer select mismatch
    wr(5'h10, cfgw(2, 1, 1, 3));
    wr(5'h18, 32'h1);
    ticks(20);
    check("R4 other timer select ignored", {31'b0, irq_o}, 32'h0);

    // R4 period zero acts as one
    wr(5'h00, 32'hC000_0001);
    wr(5'h10, cfgw(0, 1, 1, 5));
    wr(5'h18, 32'h1);
    ticks(2);
    check("R4 period 0 irq", {31'b0, irq_o}, 32'h1);
    ticks(4);
    check("R4 period 0 stage 3", {31'b0, rst_req_o}, 32'h0);
    ticks(2);
    check("R4 period 0 stage 4", {31'b0, rst_req_o}, 32'h1);

    // R3 one-shot timer
    wr(5'h00, 32'h8000_0001);
    wr(5'h10, cfgw(1, 1, 1, 5));
    wr(5'h18, 32'h1);
    ticks(2);
    check("R3 one-shot expiry", {31'b0, irq_o}, 32'h1);
    rd(5'h00, d); check("R3 enable bit cleared", d, 32'h0000_0001);
    ticks(20);
    check("R3 one-shot no further stages", {31'b0, rst_req_o}, 32'h0);

    // R3 writing zero stops timer
    wr(5'h00, 32'hC000_0001);
    wr(5'h18, 32'h1);
    ticks(2);
    check("R3 periodic first expiry", {31'b0, irq_o}, 32'h1);
    wr(5'h00, 32'h0);
    ticks(20);
    check("R3 zero preload stops", {31'b0, rst_req_o}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule